// File: doc/BRIEF.md
# Ring cadence timer and interrupt-input unit

This block times the ringing of an analog telephone line card and watches two slow status lines from line-side parts, such as hook state or tone-decoder valid. A fast timer counts whole milliseconds and flips an output pin each time it runs out. With a 25 ms period the pin carries a 20 Hz square wave that can key a ring generator. A slow timer counts in steps of 100 ms and sets the on/off pattern of the ring. A host configures both timers and reads back their settings through a small register port.

Each timer expiry, and each change of level on either watched input in either direction, sets a sticky status bit. The host clears the status by reading it. The block registers the OR of all status bits whose mask bit is set and drives it out as one interrupt request. A one-cycle `ms_tick` pulse from elsewhere on the chip supplies the time base. The slow timer makes its 100 ms step from that tick with an internal divide-by-100 counter.

Top module: `ring_cadence_ctl`

## Requirements
- R1: Writing address 0 loads the slow timer period P from bits 6:0 and starts it. The first expiry comes on the P*100th `ms_tick` after the write. P = 0 stops the timer.
- R2: If the slow timer mode field (address 1, bits 2:0) equals 7, the slow timer reloads P at each expiry and keeps running. Any other value stops it after one expiry. Writing the mode field does not restart the timer.
- R3: Writing address 2 loads the fast timer period P from bits 5:0 and starts it. Expiry comes on the P-th `ms_tick` after the write. P = 0 stops the timer, and no further expiry or pin toggle follows.
- R4: Bit 7 of the address 2 write selects the fast timer mode. A 1 reloads the timer at each expiry. A 0 gives exactly one expiry.
- R5: `tout` is 0 after reset and inverts at every fast timer expiry. The slow timer drives no pin.
- R6: A slow timer expiry sets status bit 0 and a fast timer expiry sets status bit 1. Each bit stays set until the host reads the status.
- R7: `xin[0]` and `xin[1]` each pass through two synchronising flops. Every change of the synchronised level, rising or falling, sets status bit 2 (input 0) or bit 3 (input 1).
- R8: A read of address 5 returns the synchronised levels of `xin[0]` and `xin[1]` in bits 0 and 1, and the `tout` level in bit 2.
- R9: A read of address 3 returns the status. The bits that were returned are cleared, and a status event in the same cycle stays set. `rdata` is registered: it is valid in the cycle after `rd_en` and is 0 when no read took place.
- R10: Address 4 holds the mask in bits 3:0, where 1 enables the bit and reset gives 0. `irq` is the registered OR of the status bits ANDed with the mask, so a zero mask holds `irq` low.
- R11: A write to address 0 clears the divide-by-100 counter, so the slow timer's steps are counted from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| xin | input | 2 | Asynchronous interrupt input pins |
| tout | output | 1 | Fast timer output pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Three fast timer patterns are used. A repeating 25 ms period separates reload from one-shot behaviour by the number of pin toggles. A 3 ms one-shot must give exactly one toggle. A zero period must leave the pin still. The slow timer runs first in cyclic mode and then is switched to single mode while it is running, which shows that the mode field is applied at the next expiry without a restart. A second write of the slow period in the middle of a 100 ms step shows whether the divider is cleared, because the expiry lands at 100 or at 150 ticks depending on that. Rising and falling edges on each input, and masks of all ones and all zeros, tell edge capture apart from level capture and separate the sticky status from the request line.

// File: rtl/rcad_pkg.sv
package rcad_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_SLOW_PER  = 3'd0,
    RA_SLOW_MODE = 3'd1,
    RA_FAST_CFG  = 3'd2,
    RA_STATUS    = 3'd3,
    RA_MASK      = 3'd4,
    RA_LEVEL     = 3'd5
  } reg_addr_e;

  localparam int ST_SLOW = 0;
  localparam int ST_FAST = 1;
  localparam int ST_XIN0 = 2;
endpackage

// File: rtl/rcad_slow_timer.sv
module rcad_slow_timer #(
  parameter int PER_W    = 7,
  parameter int MODE_W   = 3,
  parameter int CYCLIC   = 7,
  parameter int PRESCALE = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [PER_W-1:0]  load_val,
  input  logic [MODE_W-1:0] mode,
  output logic [PER_W-1:0]  per,
  output logic              expire
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [PER_W-1:0] cnt;
  logic             run;
  logic             step;

  assign step = tick && (pre_cnt == PRE_LAST) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (load) begin
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      per    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        per <= load_val;
        cnt <= load_val;
        run <= (load_val != '0);
      end else if (run && step) begin
        if (cnt == PER_W'(1)) begin
          expire <= 1'b1;
          if (mode == MODE_W'(CYCLIC)) cnt <= per;
          else                         run <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0 && cnt <= per))
    else $error("slow timer count out of range");

  assert_single_stop_R2: assert property (@(posedge clk) disable iff (rst)
    (expire && $past(mode) != MODE_W'(CYCLIC)) |-> !run)
    else $error("single-shot slow timer kept running");
endmodule

// File: rtl/rcad_fast_timer.sv
module rcad_fast_timer #(
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [PER_W-1:0] load_val,
  input  logic             load_rep,
  output logic [PER_W-1:0] per,
  output logic             rep,
  output logic             expire,
  output logic             pin
);
  logic [PER_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      per    <= '0;
      rep    <= 1'b0;
      expire <= 1'b0;
      pin    <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        per <= load_val;
        rep <= load_rep;
        cnt <= load_val;
        run <= (load_val != '0);
      end else if (run && tick) begin
        if (cnt == PER_W'(1)) begin
          expire <= 1'b1;
          pin    <= ~pin;
          if (rep) cnt <= per;
          else     run <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_pin_flip_R5: assert property (@(posedge clk) disable iff (rst)
    expire |-> (pin != $past(pin)))
    else $error("fast timer pin did not toggle on expiry");

  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (expire && !rep) |-> !run)
    else $error("one-shot fast timer kept running");

  assert_zero_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (per == '0) |-> !run)
    else $error("fast timer running with zero period");
endmodule

// File: rtl/rcad_pin_watch.sv
module rcad_pin_watch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_async,
  output logic [N-1:0] level,
  output logic [N-1:0] change
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pin
      logic meta, sync, prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta <= 1'b0;
          sync <= 1'b0;
          prev <= 1'b0;
        end else begin
          meta <= pin_async[g];
          sync <= meta;
          prev <= sync;
        end
      end
      assign level[g]  = sync;
      assign change[g] = sync ^ prev;
    end
  endgenerate
endmodule

// File: rtl/ring_cadence_ctl.sv
module ring_cadence_ctl
  import rcad_pkg::*;
#(
  parameter int SLOW_PER_W = 7,
  parameter int SLOW_MODE_W = 3,
  parameter int SLOW_CYCLIC = 7,
  parameter int PRESCALE = 100,
  parameter int FAST_PER_W = 6,
  parameter int N_XIN = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_XIN-1:0]  xin,
  output logic              tout,
  output logic              irq
);
  localparam int ST_W = ST_XIN0 + N_XIN;

  logic [SLOW_MODE_W-1:0] slow_mode;
  logic [SLOW_PER_W-1:0]  slow_per;
  logic [FAST_PER_W-1:0]  fast_per;
  logic                   fast_rep;
  logic                   slow_exp, fast_exp;
  logic [N_XIN-1:0]       xlvl, xchg;
  logic [ST_W-1:0]        status, mask, st_set;
  logic                   wr_slow, wr_fast, rd_status;
  logic [DATA_W-1:0]      rd_val;

  assign wr_slow   = wr_en && (addr == RA_SLOW_PER);
  assign wr_fast   = wr_en && (addr == RA_FAST_CFG);
  assign rd_status = rd_en && (addr == RA_STATUS);

  rcad_slow_timer #(
    .PER_W(SLOW_PER_W), .MODE_W(SLOW_MODE_W),
    .CYCLIC(SLOW_CYCLIC), .PRESCALE(PRESCALE)
  ) u_slow (
    .clk(clk), .rst(rst), .tick(ms_tick), .load(wr_slow),
    .load_val(wdata[SLOW_PER_W-1:0]), .mode(slow_mode),
    .per(slow_per), .expire(slow_exp)
  );

  rcad_fast_timer #(.PER_W(FAST_PER_W)) u_fast (
    .clk(clk), .rst(rst), .tick(ms_tick), .load(wr_fast),
    .load_val(wdata[FAST_PER_W-1:0]), .load_rep(wdata[DATA_W-1]),
    .per(fast_per), .rep(fast_rep), .expire(fast_exp), .pin(tout)
  );

  rcad_pin_watch #(.N(N_XIN)) u_pins (
    .clk(clk), .rst(rst), .pin_async(xin), .level(xlvl), .change(xchg)
  );

  always_comb begin
    st_set          = '0;
    st_set[ST_SLOW] = slow_exp;
    st_set[ST_FAST] = fast_exp;
    st_set[ST_W-1:ST_XIN0] = xchg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_mode <= '0;
      mask      <= '0;
      status    <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_en && addr == RA_SLOW_MODE) slow_mode <= wdata[SLOW_MODE_W-1:0];
      if (wr_en && addr == RA_MASK)      mask      <= wdata[ST_W-1:0];
      status <= (rd_status ? '0 : status) | st_set;
      irq    <= |(status & mask);
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      RA_SLOW_PER:  rd_val[SLOW_PER_W-1:0] = slow_per;
      RA_SLOW_MODE: rd_val[SLOW_MODE_W-1:0] = slow_mode;
      RA_FAST_CFG: begin
        rd_val[FAST_PER_W-1:0] = fast_per;
        rd_val[DATA_W-1]       = fast_rep;
      end
      RA_STATUS:    rd_val[ST_W-1:0] = status;
      RA_MASK:      rd_val[ST_W-1:0] = mask;
      RA_LEVEL: begin
        rd_val[N_XIN-1:0] = xlvl;
        rd_val[N_XIN]     = tout;
      end
      default:      rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_val : '0;
  end

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_status) |-> (rdata[ST_W-1:0] == $past(status)))
    else $error("status read returned wrong value");

  assert_sticky_slow_R6: assert property (@(posedge clk) disable iff (rst)
    $past(status[ST_SLOW] && !rd_status) |-> status[ST_SLOW])
    else $error("slow status bit lost without read");

  assert_edge_capture_R7: assert property (@(posedge clk) disable iff (rst)
    xchg[0] |=> status[ST_XIN0])
    else $error("input edge not captured");

  assert_mask_block_R10: assert property (@(posedge clk) disable iff (rst)
    (mask == '0 && $past(mask) == '0) |-> !irq)
    else $error("irq raised with zero mask");
endmodule

// File: tb/test_ring_cadence_ctl.sv
module test_ring_cadence_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] xin = '0;
  logic       tout, irq;

  int checks = 0, failures = 0;
  int tick_cnt = 0, toggles = 0;
  bit done = 0;
  string phase = "R9";

  ring_cadence_ctl i_ring_cadence_ctl (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .xin(xin), .tout(tout), .irq(irq)
  );

  always #5 clk = ~clk;

  // reference model state
  int m_pre, m_lcnt, m_lrun, m_lper, m_lmode, m_lexp;
  int m_scnt, m_srun, m_sper, m_srep, m_sexp, m_tout;
  int m_s1[2], m_s2[2], m_pv[2];
  int m_st, m_mask, m_irq, m_rdata;

  always @(posedge clk) begin
    automatic int a = addr, wd = wdata;
    automatic int o_st = m_st, o_mask = m_mask, o_lexp = m_lexp, o_sexp = m_sexp;
    automatic int o_tout = m_tout, rv = 0, chg = 0;
    if (rst) begin
      m_pre = 0; m_lcnt = 0; m_lrun = 0; m_lper = 0; m_lmode = 0; m_lexp = 0;
      m_scnt = 0; m_srun = 0; m_sper = 0; m_srep = 0; m_sexp = 0; m_tout = 0;
      m_s1 = '{0, 0}; m_s2 = '{0, 0}; m_pv = '{0, 0};
      m_st = 0; m_mask = 0; m_irq = 0; m_rdata = 0;
    end else begin
      case (a)
        0: rv = m_lper;
        1: rv = m_lmode;
        2: rv = m_sper + 128 * m_srep;
        3: rv = o_st;
        4: rv = o_mask;
        5: rv = m_s2[0] + 2 * m_s2[1] + 4 * o_tout;
        default: rv = 0;
      endcase
      for (int k = 0; k < 2; k++) if (m_s2[k] != m_pv[k]) chg += (1 << (2 + k));
      // slow timer
      m_lexp = 0;
      if (wr_en && a == 0) begin
        m_pre = 0; m_lper = wd % 128; m_lcnt = m_lper; m_lrun = (m_lper != 0);
      end else begin
        automatic bit step = ms_tick && m_pre == 99;
        if (ms_tick) m_pre = (m_pre + 1) % 100;
        if (m_lrun && step) begin
          if (m_lcnt == 1) begin
            m_lexp = 1;
            if (m_lmode == 7) m_lcnt = m_lper; else m_lrun = 0;
          end else m_lcnt--;
        end
      end
      // fast timer
      m_sexp = 0;
      if (wr_en && a == 2) begin
        m_sper = wd % 64; m_srep = wd / 128; m_scnt = m_sper; m_srun = (m_sper != 0);
      end else if (m_srun && ms_tick) begin
        if (m_scnt == 1) begin
          m_sexp = 1; m_tout = 1 - m_tout;
          if (m_srep) m_scnt = m_sper; else m_srun = 0;
        end else m_scnt--;
      end
      if (wr_en && a == 1) m_lmode = wd % 8;
      if (wr_en && a == 4) m_mask = wd % 16;
      m_st = ((rd_en && a == 3) ? 0 : o_st) | chg | (o_sexp << 1) | o_lexp;
      m_irq = ((o_st & o_mask) != 0);
      m_rdata = rd_en ? rv : 0;
      for (int k = 0; k < 2; k++) begin
        m_pv[k] = m_s2[k]; m_s2[k] = m_s1[k]; m_s1[k] = xin[k];
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5", tout, m_tout, "tout");
      check("R10", irq, m_irq, "irq");
      check(phase, rdata, m_rdata, "rdata");
      if (tout != $past(tout)) toggles++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && ((tick_cnt >= 0) && ($time / 10) % 4 == 0)) begin
        ms_tick = 1'b1; tick_cnt++;
      end else ms_tick = 1'b0;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = a[2:0]; wdata = d[7:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1; addr = a[2:0];
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic wait_ticks(input int n);
    automatic int t0 = tick_cnt;
    while (tick_cnt < t0 + n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int v, t0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R5", tout, 0, "tout after reset");
    check("R10", irq, 0, "irq after reset");
    rd(4, v); check("R10", v, 0, "mask reset");
    wr(4, 15);

    // fast repeating 25 ms
    phase = "R4";
    t0 = toggles; wr(2, 128 + 25);
    rd(2, v); check("R4", v, 153, "fast cfg readback");
    wait_ticks(110);
    check("R4", toggles - t0, 4, "toggles repeating 25");
    rd(3, v); check("R6", (v >> 1) & 1, 1, "fast status");
    // fast one-shot 3 ms
    t0 = toggles; wr(2, 3);
    wait_ticks(20);
    check("R4", toggles - t0, 1, "toggles one-shot");
    // zero period
    phase = "R3";
    wr(2, 128 + 2); wr(2, 0);
    t0 = toggles; wait_ticks(30);
    check("R3", toggles - t0, 0, "toggles zero period");

    // slow timer cyclic then single
    phase = "R2";
    rd(3, v);
    wr(1, 7); wr(0, 2);
    wait_ticks(210); rd(3, v); check("R1", v & 1, 1, "slow first expiry");
    wait_ticks(200); rd(3, v); check("R2", v & 1, 1, "slow cyclic expiry");
    wr(1, 0);
    wait_ticks(200); rd(3, v); check("R2", v & 1, 1, "slow last expiry");
    wait_ticks(220); rd(3, v); check("R2", v & 1, 0, "slow stopped");

    // prescaler reset on period write
    phase = "R11";
    wr(0, 1); wait_ticks(50); wr(0, 1); rd(3, v);
    wait_ticks(90); rd(3, v); check("R11", v & 1, 0, "no early slow expiry");
    wait_ticks(20); rd(3, v); check("R11", v & 1, 1, "slow expiry after rewrite");

    // interrupt inputs
    phase = "R7";
    rd(3, v);
    @(negedge clk); xin = 2'b01;
    repeat (5) @(negedge clk);
    rd(5, v); check("R8", v & 3, 1, "level xin0 high");
    check("R10", irq, 1, "irq with mask set");
    rd(3, v); check("R7", (v >> 2) & 3, 1, "rise on xin0");
    @(negedge clk); xin = 2'b10;
    repeat (5) @(negedge clk);
    rd(5, v); check("R8", v & 3, 2, "level xin1 high");
    wr(4, 0);
    repeat (4) @(negedge clk);
    check("R10", irq, 0, "irq with zero mask");
    rd(3, v); check("R7", (v >> 2) & 3, 3, "fall xin0 rise xin1");
    rd(3, v); check("R9", v, 0, "status cleared by read");
    @(negedge clk); xin = 2'b00;
    repeat (6) @(negedge clk);
    phase = "R9";
    rd(3, v); check("R7", (v >> 3) & 1, 1, "fall on xin1");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule